// File: doc/BRIEF.md
# Key-Locked GPIO Bank

This block is one bank of general-purpose pins, from 1 to 32 of them, behind a plain 32-bit register bus. Software sees the pad levels through a synchronized input register. It changes the output data bits through one write-one-to-set register and one write-one-to-clear register, so no read-modify-write is needed. Each pin has a two-bit drive mode made of a MODE1 bit and a MODE0 bit. The mode selects input, push-pull, drive-low-only (open-drain style) or drive-high-only (open-source style).

The mode bits are protected. A write to any mode register, whether a whole word or a set or clear alias, takes effect only while a lock register holds the magic key 0xD42F. In the usual sequence, software writes the key, changes the modes, then writes zero to close the lock. Whole-word mode writes allow saved modes to be restored in one access. Each pin drives a level and an active-high output enable toward its pad cell.

Top module: `keyed_gpio_bank`

## Requirements
- R1: After reset every output data bit and every mode bit is 0 and the lock is inactive. Every pin therefore has pad_oe=0 and pad_out=0, and MODE0, MODE1 and the lock register (offset 0x60) all read 0.
- R2: A write to DATASET (0x14) sets, and a write to DATACLEAR (0x18), clears the output data bit of each pin whose write-data bit is 1. Pins whose bit is 0 keep their value.
- R3: A write to the lock register (0x60) whose bits 15:0 equal 0xD42F makes the lock active. A write with any other value in bits 15:0, including 0, makes it inactive. A read of the lock register returns the active flag in bit 31 and 0 in bits 30:0.
- R4: While the lock is inactive, writes to MODE1 (0x08), MODE0 (0x0C), MODE1_CLEAR (0x50), MODE0_SET (0x54) and MODE0_CLEAR (0x58) are ignored.
- R5: While the lock is active, MODE0_SET sets, and MODE0_CLEAR and MODE1_CLEAR clear, the matching mode bit of each pin whose write-data bit is 1. Other mode bits keep their value.
- R6: While the lock is active, a write to MODE0 or MODE1 replaces the whole register with the write data, and reading them returns the current mode bits.
- R7: Per pin, {mode1,mode0} sets the pad. 00 gives oe=0. 01 gives oe=1 with out equal to the data bit. 10 gives oe=1 and out=0 when data is 0, and oe=0 when data is 1. 11 gives oe=0 when data is 0, and oe=1 and out=1 when data is 1. pad_out is 0 whenever oe is 0.
- R8: DATAIN (0x04) returns pad_in after a two-flop synchronizer. A read launched in the cycle after pad_in changes still returns the old value, and the next read returns the new one.
- R9: The aliases DATASET, DATACLEAR, MODE1_CLEAR, MODE0_SET, MODE0_CLEAR and unmapped offsets read as 0. Register bits at or above the pin count read as 0 and ignore writes.
- R10: bus_rdata is loaded at the rising edge where bus_rd is 1 and holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned on the next edge |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, held between reads |
| pad_in | input | NPINS | Asynchronous pad levels |
| pad_out | output | NPINS | Per-pin drive level |
| pad_oe | output | NPINS | Per-pin output enable, active high |

## Verification
The bench runs with six pins, so it can check that write bits above the pin count vanish and read back as zero. It tries all five mode addresses while the lock is closed. It also tries a near-miss key 0xD42E, which a decoder that compares too few key bits would accept and which would leave the lock open. The mode table is checked with both data values on four pins at once. Swapping the open-drain and open-source rows, or gating the wrong polarity, shows up as a wrong pad_oe pattern. One read taken a cycle too early after pad_in changes must still return the old value, which catches a synchronizer that is one stage short.

// File: rtl/kgpio_pkg.sv
package kgpio_pkg;
   localparam int unsigned BUS_DW = 32;

   localparam logic [7:0] OFS_DIN   = 8'h04;
   localparam logic [7:0] OFS_MODE1 = 8'h08;
   localparam logic [7:0] OFS_MODE0 = 8'h0C;
   localparam logic [7:0] OFS_DSET  = 8'h14;
   localparam logic [7:0] OFS_DCLR  = 8'h18;
   localparam logic [7:0] OFS_M1CLR = 8'h50;
   localparam logic [7:0] OFS_M0SET = 8'h54;
   localparam logic [7:0] OFS_M0CLR = 8'h58;
   localparam logic [7:0] OFS_LOCK  = 8'h60;

   localparam logic [15:0] UNLOCK_KEY = 16'hD42F;

   typedef enum logic [1:0] {
      PAD_INPUT    = 2'b00,
      PAD_PUSHPULL = 2'b01,
      PAD_SINK     = 2'b10,
      PAD_SOURCE   = 2'b11
   } pad_mode_e;
endpackage

// File: rtl/kgpio_sync.sv
module kgpio_sync #(
   parameter int unsigned WIDTH  = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);
   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("kgpio_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[0] <= '0;
      else        stage_q[0] <= async_in;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stage_q[s] <= '0;
         else        stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[LAST];
endmodule

// File: rtl/kgpio_mode_regs.sv
module kgpio_mode_regs #(
   parameter int unsigned NPINS = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unlocked,
   input  logic             wr_m0_word,
   input  logic             wr_m1_word,
   input  logic             wr_m0_set,
   input  logic             wr_m0_clr,
   input  logic             wr_m1_clr,
   input  logic [NPINS-1:0] wdata,
   output logic [NPINS-1:0] mode0,
   output logic [NPINS-1:0] mode1
);
   logic [NPINS-1:0] m0_d, m1_d;

   always_comb begin
      m0_d = mode0;
      m1_d = mode1;
      if (unlocked) begin
         if (wr_m0_word) m0_d = wdata;
         if (wr_m0_set)  m0_d = mode0 | wdata;
         if (wr_m0_clr)  m0_d = mode0 & ~wdata;
         if (wr_m1_word) m1_d = wdata;
         if (wr_m1_clr)  m1_d = mode1 & ~wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode0 <= '0;
         mode1 <= '0;
      end else begin
         mode0 <= m0_d;
         mode1 <= m1_d;
      end
   end

   AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      !unlocked |=> ($stable(mode0) && $stable(mode1))); // R4
endmodule

// File: rtl/kgpio_pad_drive.sv
module kgpio_pad_drive
   import kgpio_pkg::*;
#(
   parameter int unsigned NPINS = 32
) (
   input  logic [NPINS-1:0] mode0,
   input  logic [NPINS-1:0] mode1,
   input  logic [NPINS-1:0] dout,
   output logic [NPINS-1:0] pad_out,
   output logic [NPINS-1:0] pad_oe
);
   for (genvar p = 0; p < NPINS; p++) begin : g_pin
      pad_mode_e sel;
      logic      en, lvl;
      assign sel = pad_mode_e'({mode1[p], mode0[p]});
      always_comb begin
         unique case (sel)
            PAD_INPUT:    begin en = 1'b0;     lvl = 1'b0;    end
            PAD_PUSHPULL: begin en = 1'b1;     lvl = dout[p]; end
            PAD_SINK:     begin en = ~dout[p]; lvl = 1'b0;    end
            PAD_SOURCE:   begin en = dout[p];  lvl = 1'b1;    end
            default:      begin en = 1'b0;     lvl = 1'b0;    end
         endcase
      end
      assign pad_oe[p]  = en;
      assign pad_out[p] = en & lvl;
   end
endmodule

// File: rtl/keyed_gpio_bank.sv
module keyed_gpio_bank
   import kgpio_pkg::*;
#(
   parameter int unsigned NPINS       = 32,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NPINS-1:0]  pad_in,
   output logic [NPINS-1:0]  pad_out,
   output logic [NPINS-1:0]  pad_oe
);
   localparam int unsigned KEY_W = $bits(UNLOCK_KEY);

   if (NPINS < 1 || NPINS > BUS_DW) begin : g_bad_npins
      $error("keyed_gpio_bank: NPINS must be 1..32");
   end
   if (ADDR_W < 7) begin : g_bad_addr
      $error("keyed_gpio_bank: ADDR_W too narrow for the register map");
   end

   function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
      return a == ADDR_W'(ofs);
   endfunction

   logic [NPINS-1:0] wbits;
   logic [NPINS-1:0] dout_q, din_sync, mode0, mode1;
   logic             lock_q;
   logic [31:0]      rd_mux;

   assign wbits = bus_wdata[NPINS-1:0];

   // lock register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             lock_q <= 1'b0;
      else if (bus_wr && hit(bus_addr, OFS_LOCK)) lock_q <= (bus_wdata[KEY_W-1:0] == UNLOCK_KEY);
   end

   // output data with set/clear aliases
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dout_q <= '0;
      else if (bus_wr) begin
         if (hit(bus_addr, OFS_DSET)) dout_q <= dout_q | wbits;
         if (hit(bus_addr, OFS_DCLR)) dout_q <= dout_q & ~wbits;
      end
   end

   kgpio_mode_regs #(.NPINS(NPINS)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .unlocked   (lock_q),
      .wr_m0_word (bus_wr && hit(bus_addr, OFS_MODE0)),
      .wr_m1_word (bus_wr && hit(bus_addr, OFS_MODE1)),
      .wr_m0_set  (bus_wr && hit(bus_addr, OFS_M0SET)),
      .wr_m0_clr  (bus_wr && hit(bus_addr, OFS_M0CLR)),
      .wr_m1_clr  (bus_wr && hit(bus_addr, OFS_M1CLR)),
      .wdata      (wbits),
      .mode0      (mode0),
      .mode1      (mode1)
   );

   kgpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (din_sync)
   );

   kgpio_pad_drive #(.NPINS(NPINS)) u_pad (
      .mode0   (mode0),
      .mode1   (mode1),
      .dout    (dout_q),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   // readback
   always_comb begin
      rd_mux = '0;
      if (hit(bus_addr, OFS_DIN))   rd_mux = 32'(din_sync);
      if (hit(bus_addr, OFS_MODE0)) rd_mux = 32'(mode0);
      if (hit(bus_addr, OFS_MODE1)) rd_mux = 32'(mode1);
      if (hit(bus_addr, OFS_LOCK))  rd_mux = {lock_q, 31'b0};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_rd) bus_rdata <= rd_mux;
   end

   AST_LOCK_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit(bus_addr, OFS_LOCK) && bus_wdata[KEY_W-1:0] == UNLOCK_KEY) |=> lock_q); // R3
   AST_LOCK_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit(bus_addr, OFS_LOCK) && bus_wdata[KEY_W-1:0] != UNLOCK_KEY) |=> !lock_q); // R3
   AST_DSET_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit(bus_addr, OFS_DSET)) |=> ((dout_q & $past(wbits)) == $past(wbits))); // R2
   AST_INPUT_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
      ((pad_oe & ~(mode0 | mode1)) == '0)); // R7
   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

// File: tb/sim_keyed_gpio_bank.sv
`timescale 1ns/1ps
module sim_keyed_gpio_bank;
   localparam int NP = 6;
   localparam logic [7:0] A_DIN = 8'h04, A_M1 = 8'h08, A_M0 = 8'h0C, A_DSET = 8'h14,
                          A_DCLR = 8'h18, A_M1CLR = 8'h50, A_M0SET = 8'h54,
                          A_M0CLR = 8'h58, A_LOCK = 8'h60;

   logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic [NP-1:0] pad_in = '0, pad_out, pad_oe;
   int errors = 0, checks = 0;

   always #4 clk = ~clk;

   keyed_gpio_bank #(.NPINS(NP)) u0 (.*);

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = a;
      @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk("R1 oe", 32'(pad_oe), 0);
      chk("R1 out", 32'(pad_out), 0);
      rd(A_M0, v);   chk("R1 mode0", v, 0);
      rd(A_M1, v);   chk("R1 mode1", v, 0);
      rd(A_LOCK, v); chk("R1 lock", v, 0);
   endtask

   task automatic t_lock;
      logic [31:0] v;
      wr(A_LOCK, 32'h1234D42F); rd(A_LOCK, v); chk("R3 key opens, bits30:0 zero", v, 32'h8000_0000);
      wr(A_LOCK, 32'h0000D42E); rd(A_LOCK, v); chk("R3 near-miss closes", v, 0);
      wr(A_LOCK, 32'h0000D42F); wr(A_LOCK, 0); rd(A_LOCK, v); chk("R3 zero releases", v, 0);
   endtask

   task automatic t_data;
      wr(A_LOCK, 32'hD42F); wr(A_M0, 32'h3F); wr(A_LOCK, 0);
      wr(A_DSET, 32'h05);       chk("R2 set", 32'(pad_out), 32'h05);
      wr(A_DCLR, 32'h01);       chk("R2 clear", 32'(pad_out), 32'h04);
      wr(A_DSET, 32'hFFFF_FFC0); chk("R2 upper bits no effect", 32'(pad_out), 32'h04);
      wr(A_DCLR, 32'h04);       chk("R2 clear to zero", 32'(pad_out), 0);
   endtask

   task automatic t_mode_locked;
      logic [31:0] v;
      wr(A_M0, 0); wr(A_M0CLR, 32'h3F); wr(A_M1, 32'h3F); wr(A_M1CLR, 32'h3F); wr(A_M0SET, 32'h3F);
      rd(A_M0, v); chk("R4 mode0 untouched", v, 32'h3F);
      rd(A_M1, v); chk("R4 mode1 untouched", v, 0);
      chk("R4 oe untouched", 32'(pad_oe), 32'h3F);
   endtask

   task automatic t_mode_write;
      logic [31:0] v;
      wr(A_LOCK, 32'hD42F);
      wr(A_M0CLR, 32'h03); rd(A_M0, v); chk("R5 mode0 clear", v, 32'h3C);
      wr(A_M0SET, 32'h01); rd(A_M0, v); chk("R5 mode0 set", v, 32'h3D);
      wr(A_M1, 32'h30);    rd(A_M1, v); chk("R6 mode1 word", v, 32'h30);
      wr(A_M1CLR, 32'h10); rd(A_M1, v); chk("R5 mode1 clear", v, 32'h20);
      wr(A_M0, 32'hFFFF_FFFF); rd(A_M0, v); chk("R9 bits above pin count", v, 32'h3F);
      wr(A_M0, 32'h12);    rd(A_M0, v); chk("R6 mode0 word", v, 32'h12);
   endtask

   task automatic t_pad_table;
      // pin0=00 pin1=01 pin2=10 pin3=11
      wr(A_M1, 32'h0C); wr(A_M0, 32'h0A); wr(A_LOCK, 0);
      wr(A_DCLR, 32'h3F);
      chk("R7 oe data0", 32'(pad_oe), 32'h06);
      chk("R7 out data0", 32'(pad_out), 32'h00);
      wr(A_DSET, 32'h3F);
      chk("R7 oe data1", 32'(pad_oe), 32'h0A);
      chk("R7 out data1", 32'(pad_out), 32'h0A);
   endtask

   task automatic t_sync;
      logic [31:0] v;
      @(negedge clk); pad_in = 6'h2A;
      rd(A_DIN, v); chk("R8 early read still old", v, 0);
      rd(A_DIN, v); chk("R8 synced value", v, 32'h2A);
      wr(A_DSET, 32'h01); chk("R10 rdata held", bus_rdata, 32'h2A);
   endtask

   task automatic t_readmap;
      logic [31:0] v;
      rd(A_DSET, v);  chk("R9 DATASET reads zero", v, 0);
      rd(A_M0SET, v); chk("R9 MODE0_SET reads zero", v, 0);
      rd(A_M1CLR, v); chk("R9 MODE1_CLEAR reads zero", v, 0);
      rd(8'h40, v);   chk("R9 unmapped reads zero", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_lock;
      t_data;
      t_mode_locked;
      t_mode_write;
      t_pad_table;
      t_sync;
      t_readmap;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule